// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Matcher

This block sits behind a CAN receiver whose bit engine has already checked the CRC of a frame. It takes a frame that passed that check (its 11-bit identifier, its remote-request bit, its length code and eight data bytes) and decides which of sixteen mailboxes receive it. A frame that fails CRC never arrives here, because the receiver does not raise the frame strobe for it. Every stored data frame leaves a sticky receive-done flag. Every accepted remote request leaves a sticky pending flag. Both flags feed two interrupt lines, which per-mailbox and global masks can suppress.

The search visits one mailbox per clock, in ascending order, starting at mailbox 0. Mailbox 0 compares through a don't-care mask, and a hit there does not end the search. Mailboxes 1 to 15 need an exact identifier match, and the first one that matches ends the search. A single frame can therefore land in mailbox 0 and in at most one other mailbox. The identifier table, the mailbox-0 mask and the interrupt masks are loaded through plain write strobes. Flags are cleared by writing ones.

Top module: `can_rx_acceptance`

## Requirements
- R1: After reset, `busy`, `drop`, `mb_we`, `rx_done`, `rr_pend`, `irq_rx` and `irq_rr` are all 0. All identifier entries, the mailbox-0 mask, the per-mailbox interrupt masks and both global interrupt masks are 0.
- R2: A `frm_valid` pulse while `busy` is 0 starts a search, and `busy` is 1 from the next cycle. The search compares one mailbox per cycle, in order 0, 1, …, 15. A frame that matches nothing keeps `busy` high for exactly 16 cycles and sets no flag and no write.
- R3: For mailboxes 1 to 15, an exact identifier match ends the search in that cycle. Only the lowest-numbered matching mailbox among 1 to 15 receives the frame.
- R4: Mailbox 0 ignores identifier bits where its mask holds 1. A match there stores the frame in mailbox 0, and the search still continues with mailbox 1.
- R5: A matched data frame (`frm_rtr` = 0) produces, in the cycle after the matching compare, a one-cycle `mb_we` with `mb_idx` = that mailbox. The frame's identifier, length code and data appear on `mb_id`, `mb_dlc` and `mb_data`, and bit `mb_idx` of `rx_done` becomes 1.
- R6: A matched remote frame (`frm_rtr` = 1) sets that mailbox's bit in `rr_pend`. It raises no `mb_we` and sets no `rx_done` bit.
- R7: A `frm_valid` pulse while `busy` is 1 is ignored: the running search and its results are unchanged. `drop` is 1 for the following cycle.
- R8: Writing 1 to a bit of `rx_clr` or `rr_clr` clears that flag. If a flag is set and cleared in the same cycle, it ends up set.
- R9: `irq_rx` is 1 when some `rx_done` bit has its `mbim` bit (bit i = mailbox i, 1 = suppress) at 0 and the global receive suppress bit is 0. `irq_rr` works the same way with `rr_pend` and the global remote suppress bit. The global bits are loaded by `gim_we` from `gim_val`: bit 0 suppresses receive interrupts and bit 1 suppresses remote interrupts.
- R10: `tbl_we` loads `tbl_id` into entry `tbl_idx`. `mask0_we` loads the mailbox-0 mask. `mbim_we` loads the per-mailbox interrupt masks. Each takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe for a frame that passed CRC |
| frm_id | input | 11 | Received identifier |
| frm_rtr | input | 1 | 1 = remote request frame |
| frm_dlc | input | 4 | Received length code |
| frm_data | input | 64 | Received data bytes |
| tbl_we | input | 1 | Identifier table write strobe |
| tbl_idx | input | 4 | Identifier table entry to write |
| tbl_id | input | 11 | Identifier to store |
| mask0_we | input | 1 | Mailbox-0 mask write strobe |
| mask0_val | input | 11 | Mailbox-0 mask, 1 = don't care |
| mbim_we | input | 1 | Per-mailbox interrupt mask write strobe |
| mbim_val | input | 16 | Per-mailbox interrupt masks, 1 = suppress |
| gim_we | input | 1 | Global interrupt mask write strobe |
| gim_val | input | 2 | Bit 0 suppresses receive interrupt, bit 1 suppresses remote interrupt |
| rx_clr | input | 16 | Write-one-to-clear for receive-done flags |
| rr_clr | input | 16 | Write-one-to-clear for remote-pending flags |
| busy | output | 1 | Search in progress |
| drop | output | 1 | One-cycle pulse: a frame arrived while busy |
| mb_we | output | 1 | Mailbox store strobe |
| mb_idx | output | 4 | Mailbox being stored |
| mb_id | output | 11 | Identifier to store |
| mb_dlc | output | 4 | Length code to store |
| mb_data | output | 64 | Data bytes to store |
| rx_done | output | 16 | Receive-done flags |
| rr_pend | output | 16 | Remote-request pending flags |
| irq_rx | output | 1 | Receive interrupt request |
| irq_rr | output | 1 | Remote-request interrupt request |

## Verification
Some properties are checked by assertions on every cycle. The search pointer must step by one while no terminating hit occurs. The search must end on the last mailbox or on a hit above mailbox 0. A strobe during a search must yield a drop pulse and leave the captured frame untouched. A flag that is set while it is being cleared must stay set, and a flag must never rise without a match. Other behaviour can only be shown by the bench's scenarios: which mailboxes one identifier actually reaches, the lowest-index choice between duplicate entries, the don't-care mask on mailbox 0, the difference between remote and data frames, the full 16-cycle duration, and how the interrupt masks gate the two request lines.

// File: rtl/can_acc_pkg.sv
// Shared widths and the captured frame record for the acceptance matcher.
package can_acc_pkg;
    localparam int ID_W   = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } can_frame_t;
endpackage

// File: rtl/can_acc_idtable.sv
// Identifier table and compare stage.
// Holds one identifier per mailbox plus a don't-care mask for mailbox 0 and
// reports whether the mailbox under the search pointer matches the frame.
// Assumes the pointer is valid whenever the caller uses the hit result.
module can_acc_idtable
    import can_acc_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [ID_W-1:0]  tbl_id,
    input  logic             mask0_we,
    input  logic [ID_W-1:0]  mask0_val,
    input  logic [IDX_W-1:0] ptr,
    input  logic [ID_W-1:0]  cmp_id,
    output logic             hit
);
    logic [ID_W-1:0] id_q [NUM_MB];
    logic [ID_W-1:0] mask0_q;

    // Store identifier entries written through the table port.
    for (genvar g = 0; g < NUM_MB; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                id_q[g] <= '0;
            else if (tbl_we && tbl_idx == IDX_W'(g))
                id_q[g] <= tbl_id;
        end
    end

    // Store the mailbox-0 don't-care mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask0_q <= '0;
        else if (mask0_we)
            mask0_q <= mask0_val;
    end

    // Compare: masked on mailbox 0, exact elsewhere.
    always_comb begin
        if (ptr == '0)
            hit = ((cmp_id ^ id_q[0]) & ~mask0_q) == '0;
        else
            hit = (cmp_id == id_q[ptr]);
    end
endmodule

// File: rtl/can_acc_scan.sv
// Search sequencer.
// Captures a frame when idle, steps a pointer over the mailboxes one per
// clock, ends on the last mailbox or on a hit above mailbox 0, and issues
// the store strobe for data frames. Strobes arriving mid-search are dropped.
module can_acc_scan
    import can_acc_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_valid,
    input  can_frame_t       frm_in,
    input  logic             hit,
    output logic             busy,
    output logic [IDX_W-1:0] ptr,
    output can_frame_t       frame_q,
    output logic             ev_valid,
    output logic             drop,
    output logic             mb_we,
    output logic [IDX_W-1:0] mb_idx,
    output can_frame_t       mb_frame
);
    logic last, stop;

    assign last     = (ptr == IDX_W'(NUM_MB - 1));
    assign stop     = hit && (ptr != '0);
    assign ev_valid = busy && hit;

    // Capture a frame when idle and advance or end the search.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            ptr     <= '0;
            frame_q <= '0;
        end else if (!busy) begin
            if (frm_valid) begin
                busy    <= 1'b1;
                ptr     <= '0;
                frame_q <= frm_in;
            end
        end else if (stop || last) begin
            busy <= 1'b0;
        end else begin
            ptr <= ptr + IDX_W'(1);
        end
    end

    // Flag strobes lost to a running search.
    always_ff @(posedge clk) begin
        if (!rst_n) drop <= 1'b0;
        else        drop <= frm_valid && busy;
    end

    // Emit the mailbox store for matched data frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mb_we    <= 1'b0;
            mb_idx   <= '0;
            mb_frame <= '0;
        end else begin
            mb_we    <= ev_valid && !frame_q.rtr;
            mb_idx   <= ptr;
            mb_frame <= frame_q;
        end
    end

    // R2
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !stop && !last) |=> (busy && ptr == $past(ptr) + IDX_W'(1)));
    // R2
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last) |=> !busy);
    // R3
    scan_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hit && ptr != '0) |=> !busy);
    // R7
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && busy) |=> (drop && frame_q == $past(frame_q)));
endmodule

// File: rtl/can_acc_flags.sv
// Flag and interrupt stage.
// Keeps receive-done and remote-pending flags (set by search hits, cleared
// by write-one), the per-mailbox and global interrupt masks, and derives
// the two interrupt lines. A set in the same cycle as a clear wins.
module can_acc_flags #(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_rtr,
    input  logic [IDX_W-1:0]  ev_idx,
    input  logic [NUM_MB-1:0] rx_clr,
    input  logic [NUM_MB-1:0] rr_clr,
    input  logic              mbim_we,
    input  logic [NUM_MB-1:0] mbim_val,
    input  logic              gim_we,
    input  logic [1:0]        gim_val,
    output logic [NUM_MB-1:0] rx_done,
    output logic [NUM_MB-1:0] rr_pend,
    output logic              irq_rx,
    output logic              irq_rr
);
    logic [NUM_MB-1:0] sel, rx_set, rr_set, mbim_q;
    logic [1:0]        gim_q;

    // Decode the hit into one-hot set vectors.
    always_comb begin
        sel    = ev_valid ? (NUM_MB'(1) << ev_idx) : '0;
        rx_set = ev_rtr ? '0 : sel;
        rr_set = ev_rtr ? sel : '0;
    end

    // Update sticky flags; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_done <= '0;
            rr_pend <= '0;
        end else begin
            rx_done <= (rx_done & ~rx_clr) | rx_set;
            rr_pend <= (rr_pend & ~rr_clr) | rr_set;
        end
    end

    // Load interrupt masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbim_q <= '0;
            gim_q  <= '0;
        end else begin
            if (mbim_we) mbim_q <= mbim_val;
            if (gim_we)  gim_q  <= gim_val;
        end
    end

    // Gate flags through both mask levels.
    assign irq_rx = |(rx_done & ~mbim_q) && !gim_q[0];
    assign irq_rr = |(rr_pend & ~mbim_q) && !gim_q[1];

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_rtr && rx_clr[ev_idx]) |=> rx_done[$past(ev_idx)]);
    // R5
    rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_done & ~$past(rx_done)) != '0) |-> $past(ev_valid && !ev_rtr));
    // R6
    rr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rr_pend & ~$past(rr_pend)) != '0) |-> $past(ev_valid && ev_rtr));
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx |-> rx_done != '0) and (irq_rr |-> rr_pend != '0));
endmodule

// File: rtl/can_rx_acceptance.sv
// Receive acceptance matcher top.
// Takes CRC-clean frames, searches the mailbox identifier table in order,
// stores data frames, records remote requests and raises interrupts.
// Assumes frm_valid is raised only for frames whose CRC was good.
module can_rx_acceptance #(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [10:0]       frm_id,
    input  logic              frm_rtr,
    input  logic [3:0]        frm_dlc,
    input  logic [63:0]       frm_data,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [10:0]       tbl_id,
    input  logic              mask0_we,
    input  logic [10:0]       mask0_val,
    input  logic              mbim_we,
    input  logic [NUM_MB-1:0] mbim_val,
    input  logic              gim_we,
    input  logic [1:0]        gim_val,
    input  logic [NUM_MB-1:0] rx_clr,
    input  logic [NUM_MB-1:0] rr_clr,
    output logic              busy,
    output logic              drop,
    output logic              mb_we,
    output logic [IDX_W-1:0]  mb_idx,
    output logic [10:0]       mb_id,
    output logic [3:0]        mb_dlc,
    output logic [63:0]       mb_data,
    output logic [NUM_MB-1:0] rx_done,
    output logic [NUM_MB-1:0] rr_pend,
    output logic              irq_rx,
    output logic              irq_rr
);
    import can_acc_pkg::*;

    can_frame_t       frm_in, frame_q, mb_frame;
    logic             hit, ev_valid;
    logic [IDX_W-1:0] ptr;

    assign frm_in = '{id: frm_id, rtr: frm_rtr, dlc: frm_dlc, data: frm_data};

    can_acc_idtable #(.NUM_MB(NUM_MB)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_id(tbl_id),
        .mask0_we(mask0_we), .mask0_val(mask0_val),
        .ptr(ptr), .cmp_id(frame_q.id), .hit(hit)
    );

    can_acc_scan #(.NUM_MB(NUM_MB)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .frm_valid(frm_valid), .frm_in(frm_in), .hit(hit),
        .busy(busy), .ptr(ptr), .frame_q(frame_q), .ev_valid(ev_valid),
        .drop(drop), .mb_we(mb_we), .mb_idx(mb_idx), .mb_frame(mb_frame)
    );

    can_acc_flags #(.NUM_MB(NUM_MB)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_rtr(frame_q.rtr), .ev_idx(ptr),
        .rx_clr(rx_clr), .rr_clr(rr_clr),
        .mbim_we(mbim_we), .mbim_val(mbim_val),
        .gim_we(gim_we), .gim_val(gim_val),
        .rx_done(rx_done), .rr_pend(rr_pend),
        .irq_rx(irq_rx), .irq_rr(irq_rr)
    );

    assign mb_id   = mb_frame.id;
    assign mb_dlc  = mb_frame.dlc;
    assign mb_data = mb_frame.data;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mb_we && !drop && rx_done == '0 && rr_pend == '0));
endmodule

// File: tb/can_rx_acceptance_tb.sv
module can_rx_acceptance_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        frm_valid = 0, frm_rtr = 0;
    logic [10:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        tbl_we = 0, mask0_we = 0, mbim_we = 0, gim_we = 0;
    logic [3:0]  tbl_idx = '0;
    logic [10:0] tbl_id = '0, mask0_val = '0;
    logic [15:0] mbim_val = '0, rx_clr = '0, rr_clr = '0;
    logic [1:0]  gim_val = '0;
    logic        busy, drop, mb_we, irq_rx, irq_rr;
    logic [3:0]  mb_idx, mb_dlc;
    logic [10:0] mb_id;
    logic [63:0] mb_data;
    logic [15:0] rx_done, rr_pend;

    int checks = 0, fails = 0;
    logic [15:0] wr_log = '0;

    can_rx_acceptance u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [10:0] id;
        logic        rtr;
        logic [15:0] hits;
    } vec_t;

    // Table: mb0 = 0x100 with mask 0x00F, mbK = 0x100+3K, mb9 duplicated to 0x10C.
    localparam vec_t VEC [0:6] = '{
        '{11'h103, 1'b0, 16'h0003},   // R4 mb0 masked + mb1
        '{11'h10C, 1'b0, 16'h0011},   // R3 mb4 wins over mb9
        '{11'h12D, 1'b0, 16'h8000},   // R3 last mailbox only
        '{11'h200, 1'b0, 16'h0000},   // R2 no match
        '{11'h10E, 1'b0, 16'h0001},   // R4 mb0 only
        '{11'h106, 1'b1, 16'h0005},   // R6 remote to mb0 and mb2
        '{11'h118, 1'b0, 16'h0100}    // R3 mb8 exact
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Log stores and compare their payload with the frame sent.
    always @(negedge clk) begin
        if (rst_n && mb_we) begin
            wr_log[mb_idx] = 1'b1;
            check("R5 payload", {mb_id, mb_dlc, mb_data[48:0]}, {frm_id, frm_dlc, frm_data[48:0]});
        end
    end

    task automatic send(input logic [10:0] id, input logic rtr);
        @(negedge clk);
        frm_id = id; frm_rtr = rtr; frm_dlc = id[3:0]; frm_data = {5'd0, id, id, id, id, id};
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        rx_clr = '1; rr_clr = '1; wr_log = '0;
        @(negedge clk);
        rx_clr = '0; rr_clr = '0;
    endtask

    task automatic wr_tbl(input int idx, input logic [10:0] id);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_id = id;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 flags", {rx_done, rr_pend}, 0);
        check("R1 irq", {irq_rx, irq_rr, mb_we, drop}, 0);

        // R10 table load
        for (int k = 1; k < 16; k++) wr_tbl(k, 11'(12'h100 + 3 * k));
        wr_tbl(0, 11'h100);
        wr_tbl(9, 11'h10C);
        @(negedge clk);
        mask0_we = 1'b1; mask0_val = 11'h00F;
        @(negedge clk);
        mask0_we = 1'b0;

        for (int v = 0; v < 7; v++) begin
            clear_all();
            send(VEC[v].id, VEC[v].rtr);
            @(negedge clk);
            check("R3/R4/R5 rx_done", rx_done, VEC[v].rtr ? 16'h0 : VEC[v].hits);
            check("R6 rr_pend", rr_pend, VEC[v].rtr ? VEC[v].hits : 16'h0);
            check("R5/R6 stores", wr_log, VEC[v].rtr ? 16'h0 : VEC[v].hits);
        end

        // R2 full search duration on a miss
        clear_all();
        @(negedge clk);
        frm_id = 11'h200; frm_rtr = 0; frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 40) begin cyc++; @(negedge clk); end
        check("R2 busy cycles", cyc, 16);

        // R7 strobe while busy is dropped
        @(negedge clk);
        frm_id = 11'h200; frm_valid = 1'b1;
        @(negedge clk);
        frm_id = 11'h106; frm_rtr = 1'b0;
        @(negedge clk);
        frm_valid = 1'b0;
        check("R7 drop pulse", drop, 1);
        while (busy) @(negedge clk);
        @(negedge clk);
        check("R7 ignored frame", {rx_done, rr_pend, wr_log}, 0);

        // R8 set wins over simultaneous clear (clear held through the search)
        clear_all();
        @(negedge clk);
        frm_id = 11'h12D; frm_rtr = 0; frm_valid = 1'b1; rx_clr = 16'h8000;
        @(negedge clk);
        frm_valid = 1'b0;
        while (busy) @(negedge clk);
        rx_clr = '0;
        check("R8 set wins", rx_done[15], 1);
        @(negedge clk);
        rx_clr = 16'h8000;
        @(negedge clk);
        rx_clr = '0;
        check("R8 clear", rx_done, 0);

        // R9 interrupt masking
        clear_all();
        send(11'h103, 1'b0);
        @(negedge clk);
        check("R9 irq_rx on", irq_rx, 1);
        mbim_we = 1'b1; mbim_val = 16'h0003;
        @(negedge clk);
        mbim_we = 1'b0;
        check("R9 mbim off", irq_rx, 0);
        mbim_we = 1'b1; mbim_val = 16'h0000; gim_we = 1'b1; gim_val = 2'b01;
        @(negedge clk);
        mbim_we = 1'b0; gim_we = 1'b0;
        check("R9 global rx off", irq_rx, 0);
        check("R9 irq_rr idle", irq_rr, 0);
        send(11'h106, 1'b1);
        @(negedge clk);
        check("R9 irq_rr on", irq_rr, 1);
        gim_we = 1'b1; gim_val = 2'b10;
        @(negedge clk);
        gim_we = 1'b0;
        check("R9 global rr off", {irq_rr, irq_rx}, 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule